// File: doc/BRIEF.md
# Ten-Limb Field Multiplier (Mixed 26/25-Bit Radix)

This block multiplies two elements of the prime field of order 2^255 - 19. Each operand arrives as ten unsigned limbs, each limb in its own 32-bit word, and the limbs alternate between 26 and 25 bits of weight. Limb n carries the weight 2^ceil(25.5*n), so the limbs sit at bit offsets 0, 26, 51, 77, 102, 128, 153, 179, 204 and 230.

A start strobe captures both operands. On the same edge the block forms nineteen-times copies of every g limb and doubled copies of every f limb. One shared 32x32->64 multiplier then works through all hundred limb pairs, one pair per cycle, and adds each product into one of ten 64-bit column accumulators. A product whose weight reaches 2^255 wraps to a low column and uses the nineteen-times copy of g, because 2^255 is congruent to 19. When two odd-indexed limbs meet, the doubled copy of f supplies the missing factor of two in the half-bit radix.

The ten column sums are left unreduced. A separate reducer normalises them. A square is computed by feeding the same vector to both operands.

Top module: `limb_field_mul`

## Requirements
- R1: After reset, done_o is 0 and all ten columns of h_o are 0.
- R2: Column k of h_o (bits 64k+63..64k) equals the sum of f_i*g_j over all limb pairs with i+j = k, where limb n of an operand is bits 32n+31..32n of its port.
- R3: A pair with i+j >= 10 is added into column i+j-10, multiplied by 19.
- R4: A pair in which both i and j are odd is multiplied by 2, on top of any factor from R3.
- R5: done_o is high for exactly one cycle, and it rises 100 clock cycles after the edge at which start_i was accepted.
- R6: start_i while a multiplication is running is ignored. Changes on f_i and g_i after the accepting edge are also ignored, and the result and the latency are those of the accepted operands.
- R7: Once done_o has pulsed, h_o holds its value until the next accepted start_i.
- R8: With f_i equal to g_i, h_o gives the column sums of the square.
- R9: With every limb at its ceiling of 2^27-1, every column is exact in 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| f_i | input | 320 | First operand, ten 32-bit limb words |
| g_i | input | 320 | Second operand, ten 32-bit limb words |
| done_o | output | 1 | One-cycle pulse when h_o is valid |
| h_o | output | 640 | Ten unreduced 64-bit column sums |

## Verification
The checks assume that every limb presented with an accepted start is below 2^27. Under that bound the doubled f copies and the nineteen-times g copies fit in 32 bits, and the column sums cannot overflow. The stimulus masks each random limb to 27 bits and draws directed cases from single-limb operands and all-ceiling operands. A limb at or above 2^27 is never driven, so the range assertion states an input contract and does not test the design.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  localparam int unsigned LIMB_W = 32;
  localparam int unsigned ACC_W  = 64;
  localparam int unsigned BOUND_W = 27;
  typedef logic [LIMB_W-1:0] word_t;
  typedef logic [ACC_W-1:0]  acc_t;
endpackage

// File: rtl/lfm_prescale.sv
module lfm_prescale
  import lfm_pkg::*;
#(
  parameter int unsigned NLIMB = 10,
  parameter int unsigned FOLD  = 19
) (
  input  word_t f_i      [NLIMB],
  input  word_t g_i      [NLIMB],
  output word_t f_dbl_o  [NLIMB],
  output word_t g_fold_o [NLIMB]
);
  for (genvar k = 0; k < NLIMB; k++) begin : g_limb
    assign f_dbl_o[k]  = {f_i[k][LIMB_W-2:0], 1'b0};
    assign g_fold_o[k] = LIMB_W'(g_i[k] * FOLD);
  end
endmodule

// File: rtl/lfm_seq.sv
module lfm_seq #(
  parameter int unsigned NLIMB = 10,
  localparam int unsigned IDX_W = $clog2(NLIMB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] row_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NLIMB - 1);

  assign load_o = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      row_o  <= '0;
      idx_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        busy_o <= 1'b1;
        row_o  <= '0;
        idx_o  <= '0;
      end else if (busy_o) begin
        if (idx_o == LAST) begin
          idx_o <= '0;
          if (row_o == LAST) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else begin
            row_o <= row_o + 1'b1;
          end
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lfm_mac.sv
module lfm_mac
  import lfm_pkg::*;
#(
  parameter int unsigned NLIMB = 10,
  localparam int unsigned IDX_W = $clog2(NLIMB),
  localparam int unsigned SUM_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] row_i,
  input  logic [IDX_W-1:0] idx_i,
  input  word_t            f_i      [NLIMB],
  input  word_t            f_dbl_i  [NLIMB],
  input  word_t            g_i      [NLIMB],
  input  word_t            g_fold_i [NLIMB],
  output acc_t             acc_o    [NLIMB]
);
  logic [SUM_W-1:0] pos_sum, pos_wrapped;
  logic [IDX_W-1:0] col;
  logic             wrap, odd_pair;
  word_t            op_a, op_b;
  acc_t             prod;

  assign pos_sum     = {1'b0, row_i} + {1'b0, idx_i};
  assign wrap        = pos_sum >= SUM_W'(NLIMB);
  assign pos_wrapped = wrap ? pos_sum - SUM_W'(NLIMB) : pos_sum;
  assign col         = pos_wrapped[IDX_W-1:0];
  // odd*odd limbs sit one bit above their column weight
  assign odd_pair    = row_i[0] & idx_i[0];
  assign op_a        = odd_pair ? f_dbl_i[row_i] : f_i[row_i];
  assign op_b        = wrap ? g_fold_i[idx_i] : g_i[idx_i];
  assign prod        = ACC_W'(op_a) * ACC_W'(op_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NLIMB; k++) acc_o[k] <= '0;
    end else if (clr_i) begin
      for (int k = 0; k < NLIMB; k++) acc_o[k] <= '0;
    end else if (en_i) begin
      acc_o[col] <= (row_i == '0) ? prod : acc_o[col] + prod;
    end
  end
endmodule

// File: rtl/limb_field_mul.sv
module limb_field_mul
  import lfm_pkg::*;
#(
  parameter int unsigned NLIMB = 10,
  parameter int unsigned FOLD  = 19,
  localparam int unsigned IDX_W = $clog2(NLIMB)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NLIMB*LIMB_W-1:0]  f_i,
  input  logic [NLIMB*LIMB_W-1:0]  g_i,
  output logic                     done_o,
  output logic [NLIMB*ACC_W-1:0]   h_o
);
  word_t f_w [NLIMB], g_w [NLIMB], fd_w [NLIMB], gf_w [NLIMB];
  word_t f_q [NLIMB], g_q [NLIMB], fd_q [NLIMB], gf_q [NLIMB];
  acc_t  acc [NLIMB];
  logic  load, busy;
  logic [IDX_W-1:0] row, idx;

  for (genvar k = 0; k < NLIMB; k++) begin : g_unpack
    assign f_w[k] = f_i[k*LIMB_W +: LIMB_W];
    assign g_w[k] = g_i[k*LIMB_W +: LIMB_W];
    assign h_o[k*ACC_W +: ACC_W] = acc[k];
  end

  lfm_prescale #(.NLIMB(NLIMB), .FOLD(FOLD)) u_pre (
    .f_i(f_w), .g_i(g_w), .f_dbl_o(fd_w), .g_fold_o(gf_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NLIMB; k++) begin
        f_q[k] <= '0; g_q[k] <= '0; fd_q[k] <= '0; gf_q[k] <= '0;
      end
    end else if (load) begin
      for (int k = 0; k < NLIMB; k++) begin
        f_q[k] <= f_w[k]; g_q[k] <= g_w[k]; fd_q[k] <= fd_w[k]; gf_q[k] <= gf_w[k];
      end
    end
  end

  lfm_seq #(.NLIMB(NLIMB)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .load_o(load),
    .busy_o(busy), .done_o(done_o), .row_o(row), .idx_o(idx)
  );

  lfm_mac #(.NLIMB(NLIMB)) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load), .en_i(busy),
    .row_i(row), .idx_i(idx), .f_i(f_q), .f_dbl_i(fd_q), .g_i(g_q),
    .g_fold_i(gf_q), .acc_o(acc)
  );
endmodule

// File: rtl/limb_field_mul_chk.sv
module limb_field_mul_chk
  import lfm_pkg::*;
#(
  parameter int unsigned NLIMB = 10
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic [NLIMB*LIMB_W-1:0] f_i,
  input logic [NLIMB*LIMB_W-1:0] g_i,
  input logic                    done_o,
  input logic [NLIMB*ACC_W-1:0]  h_o,
  input logic                    busy_i
);
  localparam int unsigned PAIRS = NLIMB * NLIMB;
  localparam int unsigned CNT_W = $clog2(PAIRS + 1) + 1;

  logic [CNT_W-1:0] busy_cnt;
  logic             in_range;

  always_comb begin
    in_range = 1'b1;
    for (int k = 0; k < NLIMB; k++) begin
      if (f_i[k*LIMB_W+BOUND_W +: LIMB_W-BOUND_W] != '0) in_range = 1'b0;
      if (g_i[k*LIMB_W+BOUND_W +: LIMB_W-BOUND_W] != '0) in_range = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= '0;
    else if (start_i && !busy_i) busy_cnt <= '0;
    else if (busy_i) busy_cnt <= busy_cnt + 1'b1;
  end

  // input contract: limbs below 2^27 (R9)
  p_limb_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |-> in_range);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_cnt == CNT_W'(PAIRS)));

  p_busy_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && start_i && busy_cnt < CNT_W'(PAIRS - 1)) |=> busy_i);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(h_o));
endmodule

bind limb_field_mul limb_field_mul_chk #(.NLIMB(NLIMB)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .f_i(f_i), .g_i(g_i),
  .done_o(done_o), .h_o(h_o), .busy_i(busy)
);

// File: tb/limb_field_mul_test.sv
module limb_field_mul_test;
  localparam int NL = 10;
  localparam int FW = NL * 32;
  localparam int HW = NL * 64;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [FW-1:0] f_in = '0, g_in = '0;
  logic done;
  logic [HW-1:0] h;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  limb_field_mul uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .f_i(f_in), .g_i(g_in), .done_o(done), .h_o(h)
  );

  function automatic int offs(input int n);
    return (51 * n + 1) / 2;
  endfunction

  function automatic logic [HW-1:0] model(input logic [FW-1:0] f, input logic [FW-1:0] g);
    logic [63:0] col [NL];
    logic [63:0] t;
    logic [HW-1:0] r;
    for (int k = 0; k < NL; k++) col[k] = '0;
    for (int i = 0; i < NL; i++)
      for (int j = 0; j < NL; j++) begin
        int e = offs(i) + offs(j);
        int w = (e >= 255) ? 1 : 0;
        int c = (i + j) % NL;
        int sh = e - 255 * w - offs(c);
        t = 64'(f[i*32 +: 32]) * 64'(g[j*32 +: 32]);
        t = t << sh;
        if (w != 0) t = t * 64'd19;
        col[c] = col[c] + t;
      end
    for (int k = 0; k < NL; k++) r[k*64 +: 64] = col[k];
    return r;
  endfunction

  function automatic logic [FW-1:0] rnd_op();
    logic [FW-1:0] v;
    for (int k = 0; k < NL; k++) v[k*32 +: 32] = $urandom & 32'h07FF_FFFF;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_cols(input string tag, input logic [HW-1:0] exp);
    for (int k = 0; k < NL; k++) chk(tag, h[k*64 +: 64], exp[k*64 +: 64]);
  endtask

  // runs one multiply; optionally disturbs with a mid-run start (R6)
  task automatic run_op(input logic [FW-1:0] f, input logic [FW-1:0] g,
                        input bit disturb, output int cyc);
    @(negedge clk);
    f_in = f; g_in = g; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 300) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 30) begin
        f_in = rnd_op(); g_in = rnd_op(); start = 1'b1;
      end
      if (disturb && cyc == 31) start = 1'b0;
    end
  endtask

  task automatic directed(input string tag, input int fi, input logic [31:0] fv,
                          input int gj, input logic [31:0] gv,
                          input int col, input logic [63:0] val);
    logic [FW-1:0] f = '0, g = '0;
    logic [HW-1:0] e = '0;
    int cyc;
    f[fi*32 +: 32] = fv; g[gj*32 +: 32] = gv;
    e[col*64 +: 64] = val;
    run_op(f, g, 1'b0, cyc);
    chk_cols(tag, e);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] fa, ga;
    logic [HW-1:0] saved;
    int cyc;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", 64'(done), 64'd0);
    chk_cols("R1 h", '0);

    directed("R2 f0*g3", 0, 32'd5, 3, 32'd7, 3, 64'd35);
    directed("R4 f1*g1", 1, 32'd1, 1, 32'd1, 2, 64'd2);
    directed("R3 f2*g9", 2, 32'd3, 9, 32'd1, 1, 64'd57);
    directed("R3 R4 f9*g9", 9, 32'd1, 9, 32'd1, 8, 64'd38);
    directed("R2 f4*g5", 4, 32'h07FF_FFFF, 5, 32'h07FF_FFFF, 9, 64'h003F_FFFF_F000_0001);

    for (int n = 0; n < 12; n++) begin
      fa = rnd_op(); ga = rnd_op();
      run_op(fa, ga, 1'b0, cyc);
      chk("R5 latency", 64'(cyc), 64'd100);
      chk_cols("R2 R3 R4 random", model(fa, ga));
      @(negedge clk);
      chk("R5 pulse", 64'(done), 64'd0);
    end

    for (int n = 0; n < 4; n++) begin
      fa = rnd_op();
      run_op(fa, fa, 1'b0, cyc);
      chk_cols("R8 square", model(fa, fa));
    end

    for (int k = 0; k < NL; k++) begin
      fa[k*32 +: 32] = 32'h07FF_FFFF;
      ga[k*32 +: 32] = 32'h07FF_FFFF;
    end
    run_op(fa, ga, 1'b0, cyc);
    chk_cols("R9 ceiling", model(fa, ga));

    fa = rnd_op(); ga = rnd_op();
    run_op(fa, ga, 1'b1, cyc);
    chk("R6 latency", 64'(cyc), 64'd100);
    chk_cols("R6 ignored start", model(fa, ga));

    saved = h;
    f_in = rnd_op(); g_in = rnd_op();
    repeat (20) @(negedge clk);
    chk_cols("R7 hold", saved);
    chk("R7 no done", 64'(done), 64'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule